// File: doc/BRIEF.md
# Frequency Lock Detector with Sticky Loss-of-Lock Flag

This block decides whether a local oscillator runs at its target rate. It counts the rising edges of the local clock over a fixed window of reference-clock cycles and compares the count with the count the target rate should give. The difference is measured in parts per million of that expected count. A large error raises a loss-of-lock indication. The indication clears only when the error has shrunk well below the level that raised it, and it holds its state for errors between the two levels. Each time loss of lock is raised, the block sends a one-cycle request to restart frequency acquisition.

A status flag records that loss of lock has happened since it was last cleared. The flag is cleared by taking its control bit high and then low again. A second control bit, toggled the same way, restarts acquisition without touching the other control inputs. The loss-of-lock output pin shows either the live indication or the recorded flag. Two squelch policies decide how a squelch input gates the enables of the recovered clock and data outputs.

The local clock is counted in its own domain with a Gray-coded counter. That counter is sampled into the reference domain through a two-stage synchronizer. Control inputs and status outputs are plain level signals in the reference domain. The block carries no data stream, so it has no valid/ready handshake.

Top module: `freq_lock_monitor`

## Requirements
- R1: At the end of each measurement window, if the local-clock edge count differs from the expected count (LO_MULT times 2^WIN_LOG2) by more than LOSE_PPM parts per million, the live loss-of-lock indication is 1 one cycle later.
- R2: The live indication goes to 0 only after a window whose error is within LOCK_PPM parts per million. An error between LOCK_PPM and LOSE_PPM leaves the indication unchanged.
- R3: After reset, `lol_pin` is 1 (acquiring), `lol_sticky` is 0 and `acq_req` is 0.
- R4: `lol_sticky` becomes 1 one cycle after each rise of the live indication caused by a measurement. It stays 1 after lock is regained.
- R5: `lol_sticky` is cleared on the first clock edge at which `sticky_clr_bit` reads 0, having read 1 at the edge before. While the bit is held at 1, nothing is cleared. After clearing, the flag stays 0 until the next loss-of-lock event.
- R6: With `pin_static_mode` = 1, `lol_pin` equals `lol_sticky`. With `pin_static_mode` = 0, `lol_pin` shows the live indication.
- R7: A 1-to-0 transition of `sys_restart_bit` does the following on the edge where it is seen: it forces the live indication to 1, restarts the measurement window, clears `lol_sticky` and pulses `acq_req`. A forced rise does not set `lol_sticky`.
- R8: `acq_req` is a one-cycle pulse one cycle after each measurement-caused rise of the live indication.
- R9: With `squelch_mode` = 0, `squelch_in` = 1 drives both `clk_out_en` and `data_out_en` to 0. `squelch_in` = 0 drives both to 1.
- R10: With `squelch_mode` = 1, `squelch_in` = 1 gives `data_out_en` = 0 and `clk_out_en` = 1. `squelch_in` = 0 gives `clk_out_en` = 0 and `data_out_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; sets the window and runs all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lo | input | 1 | Local oscillator clock being measured |
| pin_static_mode | input | 1 | 1: pin shows the recorded flag; 0: pin shows live loss of lock |
| sticky_clr_bit | input | 1 | Flag clear control; acts on its 1-to-0 transition |
| sys_restart_bit | input | 1 | Acquisition restart control; acts on its 1-to-0 transition |
| squelch_mode | input | 1 | 0: squelch gates both enables; 1: split policy |
| squelch_in | input | 1 | Squelch request level |
| lol_pin | output | 1 | Loss-of-lock output pin |
| lol_sticky | output | 1 | Recorded loss-of-lock flag |
| acq_req | output | 1 | One-cycle acquisition restart request |
| clk_out_en | output | 1 | Enable for the recovered clock output |
| data_out_en | output | 1 | Enable for the recovered data output |

## Verification
A wrong count baseline or a corrupt synchronized count appears on `lol_pin` within two measurement windows. A locked oscillator would show loss of lock, or a badly off one would stay locked. A hysteresis register that drifts between windows shows up as a change of `lol_pin` in the middle of a window, with no window end or restart to account for it. A flag or edge-detect register in the wrong state shows at once on `lol_sticky` and `acq_req`. Examples are a flag cleared while its control bit is still high, or a flag left set after a restart.

// File: rtl/lockdet_pkg.sv
`timescale 1ps/1ps
package lockdet_pkg;

  typedef enum logic {
    SQ_BOTH  = 1'b0,
    SQ_SPLIT = 1'b1
  } sq_policy_e;

  // Converts a parts-per-million limit into an edge-count distance.
  function automatic int ppm_to_count(input longint base, input longint ppm);
    longint prod;
    prod = base * ppm;
    return int'(prod / 64'sd1000000);
  endfunction

endpackage

// File: rtl/lockdet_lo_count.sv
`timescale 1ps/1ps
module lockdet_lo_count #(
  parameter int CW = 21
) (
  input  logic          clk_lo,
  input  logic          rst_n,
  output logic [CW-1:0] gray_o
);
  logic [1:0]    rst_pipe;
  logic          lo_rst_n;
  logic [CW-1:0] bin_q;
  logic [CW-1:0] bin_nx;

  always_ff @(posedge clk_lo or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign lo_rst_n = rst_pipe[1];

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk_lo or negedge lo_rst_n) begin
    if (!lo_rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/lockdet_window.sv
`timescale 1ps/1ps
module lockdet_window #(
  parameter int CW       = 21,
  parameter int WIN_LOG2 = 16
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] gray_in,
  output logic          meas_valid,
  output logic [CW-1:0] meas_delta
);
  logic [CW-1:0]       sync1_g, sync2_g;
  logic [CW-1:0]       sync_bin;
  logic [CW-1:0]       base_q;
  logic                have_base;
  logic [WIN_LOG2-1:0] win_cnt;
  logic                win_end;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync1_g <= '0;
      sync2_g <= '0;
    end else begin
      sync1_g <= gray_in;
      sync2_g <= sync1_g;
    end
  end

  for (genvar i = 0; i < CW; i++) begin : g_g2b
    assign sync_bin[i] = ^sync2_g[CW-1:i];
  end

  assign win_end = &win_cnt;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt    <= '0;
      base_q     <= '0;
      have_base  <= 1'b0;
      meas_valid <= 1'b0;
      meas_delta <= '0;
    end else if (restart) begin
      win_cnt    <= '0;
      have_base  <= 1'b0;
      meas_valid <= 1'b0;
    end else begin
      win_cnt    <= win_cnt + 1'b1;
      meas_valid <= win_end && have_base;
      if (win_end) begin
        meas_delta <= sync_bin - base_q;
        base_q     <= sync_bin;
        have_base  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lockdet_hyst.sv
`timescale 1ps/1ps
module lockdet_hyst #(
  parameter int CW    = 21,
  parameter int EXP_C = 262144,
  parameter int HI_C  = 262,
  parameter int LO_C  = 65
) (
  input  logic          clk_ref,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          meas_valid,
  input  logic [CW-1:0] meas_delta,
  output logic          lol_live,
  output logic          lol_rise
);
  localparam logic [CW:0] EXP_V = (CW+1)'(EXP_C);
  localparam logic [CW:0] HI_V  = (CW+1)'(HI_C);
  localparam logic [CW:0] LO_V  = (CW+1)'(LO_C);

  logic signed [CW:0] err;
  logic [CW:0]        mag;
  logic               too_far, close_in;

  assign err      = $signed({1'b0, meas_delta}) - $signed(EXP_V);
  assign mag      = err[CW] ? (~err + 1'b1) : err;
  assign too_far  = mag > HI_V;
  assign close_in = mag <= LO_V;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      lol_live <= 1'b1;
      lol_rise <= 1'b0;
    end else if (restart) begin
      lol_live <= 1'b1;
      lol_rise <= 1'b0;
    end else begin
      lol_rise <= 1'b0;
      if (meas_valid) begin
        if (too_far) begin
          lol_live <= 1'b1;
          lol_rise <= ~lol_live;
        end else if (close_in) begin
          lol_live <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lockdet_ctrl.sv
`timescale 1ps/1ps
module lockdet_ctrl
  import lockdet_pkg::*;
(
  input  logic clk_ref,
  input  logic rst_n,
  input  logic pin_static_mode,
  input  logic sticky_clr_bit,
  input  logic sys_restart_bit,
  input  logic squelch_mode,
  input  logic squelch_in,
  input  logic lol_live,
  input  logic lol_rise,
  output logic restart,
  output logic lol_pin,
  output logic lol_sticky,
  output logic acq_req,
  output logic clk_out_en,
  output logic data_out_en
);
  logic clr_q, rst_q, clr_fall;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      clr_q <= sticky_clr_bit;
      rst_q <= sys_restart_bit;
    end
  end

  assign clr_fall = clr_q & ~sticky_clr_bit;
  assign restart  = rst_q & ~sys_restart_bit;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      lol_sticky <= 1'b0;
      acq_req    <= 1'b0;
    end else begin
      acq_req <= lol_rise | restart;
      if (lol_rise)                 lol_sticky <= 1'b1;
      else if (clr_fall || restart) lol_sticky <= 1'b0;
    end
  end

  assign lol_pin = pin_static_mode ? lol_sticky : lol_live;

  always_comb begin
    case (sq_policy_e'(squelch_mode))
      SQ_SPLIT: begin
        clk_out_en  = squelch_in;
        data_out_en = ~squelch_in;
      end
      default: begin
        clk_out_en  = ~squelch_in;
        data_out_en = ~squelch_in;
      end
    endcase
  end
endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ps/1ps
module freq_lock_monitor #(
  parameter int WIN_LOG2  = 16,
  parameter int LO_MULT   = 4,
  parameter int LOSE_PPM  = 1000,
  parameter int LOCK_PPM  = 250
) (
  input  logic clk_ref,
  input  logic rst_n,
  input  logic clk_lo,
  input  logic pin_static_mode,
  input  logic sticky_clr_bit,
  input  logic sys_restart_bit,
  input  logic squelch_mode,
  input  logic squelch_in,
  output logic lol_pin,
  output logic lol_sticky,
  output logic acq_req,
  output logic clk_out_en,
  output logic data_out_en
);
  localparam int MULT_W = $clog2(LO_MULT + 1);
  localparam int CW     = WIN_LOG2 + MULT_W + 2;
  localparam int EXP    = LO_MULT << WIN_LOG2;
  localparam int HI     = lockdet_pkg::ppm_to_count(longint'(EXP), longint'(LOSE_PPM));
  localparam int LO     = lockdet_pkg::ppm_to_count(longint'(EXP), longint'(LOCK_PPM));

  logic [CW-1:0] lo_gray;
  logic          meas_valid;
  logic [CW-1:0] meas_delta;
  logic          lol_live, lol_rise, restart;

  lockdet_lo_count #(.CW(CW)) u_cnt (
    .clk_lo (clk_lo),
    .rst_n  (rst_n),
    .gray_o (lo_gray)
  );

  lockdet_window #(.CW(CW), .WIN_LOG2(WIN_LOG2)) u_win (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .restart    (restart),
    .gray_in    (lo_gray),
    .meas_valid (meas_valid),
    .meas_delta (meas_delta)
  );

  lockdet_hyst #(.CW(CW), .EXP_C(EXP), .HI_C(HI), .LO_C(LO)) u_hyst (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .restart    (restart),
    .meas_valid (meas_valid),
    .meas_delta (meas_delta),
    .lol_live   (lol_live),
    .lol_rise   (lol_rise)
  );

  lockdet_ctrl u_ctrl (
    .clk_ref         (clk_ref),
    .rst_n           (rst_n),
    .pin_static_mode (pin_static_mode),
    .sticky_clr_bit  (sticky_clr_bit),
    .sys_restart_bit (sys_restart_bit),
    .squelch_mode    (squelch_mode),
    .squelch_in      (squelch_in),
    .lol_live        (lol_live),
    .lol_rise        (lol_rise),
    .restart         (restart),
    .lol_pin         (lol_pin),
    .lol_sticky      (lol_sticky),
    .acq_req         (acq_req),
    .clk_out_en      (clk_out_en),
    .data_out_en     (data_out_en)
  );
endmodule

// File: rtl/lockdet_chk.sv
`timescale 1ps/1ps
module lockdet_chk #(
  parameter int CW    = 21,
  parameter int EXP_C = 262144,
  parameter int HI_C  = 262,
  parameter int LO_C  = 65
) (
  input logic          clk_ref,
  input logic          rst_n,
  input logic          pin_static_mode,
  input logic          sticky_clr_bit,
  input logic          sys_restart_bit,
  input logic          squelch_mode,
  input logic          squelch_in,
  input logic          lol_pin,
  input logic          lol_sticky,
  input logic          acq_req,
  input logic          clk_out_en,
  input logic          data_out_en,
  input logic          meas_valid,
  input logic [CW-1:0] meas_delta,
  input logic          lol_live,
  input logic          lol_rise,
  input logic          restart
);
  localparam logic [CW:0] EXP_V = (CW+1)'(EXP_C);
  localparam logic [CW:0] HI_V  = (CW+1)'(HI_C);
  localparam logic [CW:0] LO_V  = (CW+1)'(LO_C);

  logic signed [CW:0] e;
  logic [CW:0]        m;
  assign e = $signed({1'b0, meas_delta}) - $signed(EXP_V);
  assign m = e[CW] ? (~e + 1'b1) : e;

  AST_LOL_SET_WIDE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_valid && (m > HI_V) && !restart) |=> lol_live); // R1
  AST_LOL_CLEAR_NARROW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (meas_valid && (m <= LO_V) && !restart) |=> !lol_live); // R2
  AST_LOL_HOLD_MIDWINDOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!meas_valid && !restart) |=> $stable(lol_live)); // R2
  AST_STICKY_ON_RISE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lol_rise |=> lol_sticky); // R4
  AST_STICKY_FALL_CAUSE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(lol_sticky) |-> ((!$past(sticky_clr_bit) && $past(sticky_clr_bit, 2)) ||
                           (!$past(sys_restart_bit) && $past(sys_restart_bit, 2)))); // R5
  AST_PIN_MIRROR: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pin_static_mode |-> (lol_pin == lol_sticky)); // R6
  AST_RESTART_EFFECT: assert property (@(posedge clk_ref) disable iff (!rst_n)
    restart |=> (lol_live && acq_req && !lol_sticky)); // R7
  AST_ACQ_AFTER_RISE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    lol_rise |=> acq_req); // R8
  AST_SQ_BOTH_OFF: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!squelch_mode && squelch_in) |-> (!clk_out_en && !data_out_en)); // R9
  AST_SQ_SPLIT_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
    squelch_mode |-> ((clk_out_en != data_out_en) && (data_out_en == !squelch_in))); // R10
endmodule

bind freq_lock_monitor lockdet_chk #(
  .CW(CW), .EXP_C(EXP), .HI_C(HI), .LO_C(LO)
) u_chk (
  .clk_ref         (clk_ref),
  .rst_n           (rst_n),
  .pin_static_mode (pin_static_mode),
  .sticky_clr_bit  (sticky_clr_bit),
  .sys_restart_bit (sys_restart_bit),
  .squelch_mode    (squelch_mode),
  .squelch_in      (squelch_in),
  .lol_pin         (lol_pin),
  .lol_sticky      (lol_sticky),
  .acq_req         (acq_req),
  .clk_out_en      (clk_out_en),
  .data_out_en     (data_out_en),
  .meas_valid      (meas_valid),
  .meas_delta      (meas_delta),
  .lol_live        (lol_live),
  .lol_rise        (lol_rise),
  .restart         (restart)
);

// File: tb/freq_lock_monitor_test.sv
`timescale 1ps/1ps
module freq_lock_monitor_test;
  localparam int WL   = 12;
  localparam int WIN  = 1 << WL;
  localparam int TREF = 5000;

  logic clk_ref = 1'b0, clk_lo = 1'b0, rst_n = 1'b0;
  logic pin_static_mode = 1'b0, sticky_clr_bit = 1'b0, sys_restart_bit = 1'b0;
  logic squelch_mode = 1'b0, squelch_in = 1'b0;
  logic lol_pin, lol_sticky, acq_req, clk_out_en, data_out_en;

  int checks = 0, fails = 0, acq_cnt = 0;
  int lo_per = 1250;
  bit exp_ce = 1'b1, exp_de = 1'b1;
  bit done = 1'b0;

  typedef struct {
    string req;
    bit    lol;
    bit    st;
    bit    ce;
    bit    de;
  } exp_t;
  exp_t sb[$];

  freq_lock_monitor #(.WIN_LOG2(WL), .LO_MULT(4)) uut (
    .clk_ref(clk_ref), .rst_n(rst_n), .clk_lo(clk_lo),
    .pin_static_mode(pin_static_mode), .sticky_clr_bit(sticky_clr_bit),
    .sys_restart_bit(sys_restart_bit), .squelch_mode(squelch_mode),
    .squelch_in(squelch_in), .lol_pin(lol_pin), .lol_sticky(lol_sticky),
    .acq_req(acq_req), .clk_out_en(clk_out_en), .data_out_en(data_out_en)
  );

  always #(TREF/2) clk_ref = ~clk_ref;

  initial forever begin
    #(lo_per / 2) clk_lo = 1'b1;
    #(lo_per - lo_per / 2) clk_lo = 1'b0;
  end

  always @(negedge clk_ref) if (rst_n && acq_req) acq_cnt++;

  // Monitor: pops expected items and compares them with the ports.
  initial forever begin
    @(negedge clk_ref);
    while (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      checks++;
      if ({lol_pin, lol_sticky, clk_out_en, data_out_en} !== {it.lol, it.st, it.ce, it.de}) begin
        fails++;
        $display("FAIL %s actual pin/sticky/ce/de=%b%b%b%b expected=%b%b%b%b", it.req,
                 lol_pin, lol_sticky, clk_out_en, data_out_en, it.lol, it.st, it.ce, it.de);
      end
    end
  end

  task automatic push_exp(input string req, input bit lol, input bit st);
    exp_t it;
    it.req = req; it.lol = lol; it.st = st; it.ce = exp_ce; it.de = exp_de;
    sb.push_back(it);
    @(negedge clk_ref);
  endtask

  task automatic check_acq(input string req, input int expv);
    checks++;
    if (acq_cnt != expv) begin
      fails++;
      $display("FAIL %s acq pulses actual=%0d expected=%0d", req, acq_cnt, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    push_exp("R3 reset state", 1'b1, 1'b0);
    check_acq("R3 no request at reset", 0);

    squelch_in = 1'b1; exp_ce = 1'b0; exp_de = 1'b0;
    wait_cyc(1); push_exp("R9 mode0 squelch high", 1'b1, 1'b0);
    squelch_in = 1'b0; exp_ce = 1'b1; exp_de = 1'b1;
    wait_cyc(1); push_exp("R9 mode0 squelch low", 1'b1, 1'b0);
    squelch_mode = 1'b1; squelch_in = 1'b1; exp_ce = 1'b1; exp_de = 1'b0;
    wait_cyc(1); push_exp("R10 mode1 squelch high", 1'b1, 1'b0);
    squelch_in = 1'b0; exp_ce = 1'b0; exp_de = 1'b1;
    wait_cyc(1); push_exp("R10 mode1 squelch low", 1'b1, 1'b0);
    squelch_mode = 1'b0; exp_ce = 1'b1; exp_de = 1'b1;

    wait_cyc(3 * WIN);
    push_exp("R2 lock at nominal rate", 1'b0, 1'b0);

    lo_per = 1248;
    wait_cyc(3 * WIN);
    push_exp("R1 lose lock at +1600ppm, R4 flag set", 1'b1, 1'b1);
    check_acq("R8 request on loss", 1);

    lo_per = 1249;
    wait_cyc(3 * WIN);
    push_exp("R2 hold lost at +800ppm", 1'b1, 1'b1);

    lo_per = 1250;
    wait_cyc(3 * WIN);
    push_exp("R4 relock keeps flag", 1'b0, 1'b1);

    lo_per = 1251;
    wait_cyc(3 * WIN);
    push_exp("R1 hold locked at -800ppm", 1'b0, 1'b1);

    pin_static_mode = 1'b1;
    wait_cyc(1); push_exp("R6 pin mirrors flag", 1'b1, 1'b1);
    pin_static_mode = 1'b0;
    wait_cyc(1); push_exp("R6 pin shows live", 1'b0, 1'b1);

    sticky_clr_bit = 1'b1;
    wait_cyc(3); push_exp("R5 no clear while high", 1'b0, 1'b1);
    sticky_clr_bit = 1'b0;
    wait_cyc(2); push_exp("R5 cleared on falling", 1'b0, 1'b0);
    lo_per = 1250;
    wait_cyc(2 * WIN);
    push_exp("R5 stays clear while locked", 1'b0, 1'b0);

    lo_per = 1252;
    wait_cyc(3 * WIN);
    push_exp("R1 lose lock at -1600ppm", 1'b1, 1'b1);
    check_acq("R8 second request", 2);

    lo_per = 1250;
    wait_cyc(3 * WIN);
    push_exp("R2 relock", 1'b0, 1'b1);

    sys_restart_bit = 1'b1;
    wait_cyc(2); push_exp("R7 no action while high", 1'b0, 1'b1);
    sys_restart_bit = 1'b0;
    wait_cyc(3); push_exp("R7 restart forces acquiring", 1'b1, 1'b0);
    check_acq("R7 restart request", 3);
    wait_cyc(3 * WIN);
    push_exp("R7 relock after restart without flag", 1'b0, 1'b0);
    check_acq("R8 no request for forced rise", 3);

    wait_cyc(3);
    done = 1'b1;
    finish_run();
  end
endmodule